// File: doc/BRIEF.md
# Register Rename Unit with Committed-State Map

This block gives each architectural register name a physical register tag, for an out-of-order core whose physical register file is the only place register values are kept. Each cycle the front end may present one instruction with two source register numbers and an optional destination. The block returns a physical tag for each source, a newly allocated tag for the destination, and the tag that the destination was mapped to before this instruction.

The core passes that previous tag along with the instruction. When the instruction commits in program order, the commit port writes the instruction's destination tag into a second map that holds only committed state, and it returns the previous tag to the free pool. A free bit vector with one bit per physical register tracks which tags can be allocated.

On a flush, caused by an exception or a misprediction, the speculative map is overwritten in one cycle with the committed map. In the same cycle the free pool is rebuilt so that it holds every physical register the committed map does not reference.

Top module: `reg_rename`

## Requirements
- R1: After reset both maps are the identity (architectural register i maps to physical tag i), physical tags 0 to 15 are busy, tags 16 to 63 are free, and `ren_ready` is 1.
- R2: `ren_psrc0` and `ren_psrc1` show, combinationally, the current speculative-map entries for `ren_src0` and `ren_src1`.
- R3: A rename that fires (`ren_valid`, `ren_ready`, no `flush`) with `ren_dst_en` = 1 receives in `ren_pdst` the lowest-numbered free tag, and that tag leaves the free pool.
- R4: `ren_pold` shows the speculative mapping of `ren_dst` before the rename. From the next cycle, the destination maps to the allocated tag.
- R5: When a source names the same architectural register as the destination of the same instruction, the source gets the old mapping, not the new tag.
- R6: `ren_ready` is 0 exactly when the free pool is empty. While it is 0 a presented rename has no effect and must be held by the sender.
- R7: A commit (`cmt_valid` and `cmt_dst_en`) writes `cmt_pdst` into the committed map at `cmt_dst` and frees `cmt_pold`. The freed tag can be allocated from the next cycle on, never in the commit cycle.
- R8: A `flush` copies the committed map, including any commit made in the same cycle, over the speculative map. A rename presented in the flush cycle is discarded.
- R9: After a flush the free pool holds exactly those physical tags that no committed-map entry references.
- R10: A rename with `ren_dst_en` = 0 allocates nothing and leaves the map unchanged.
- R11: No physical tag is handed out while it is still live, and the free pool never holds more than 48 tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request present |
| ren_ready | output | 1 | A free tag exists, so the rename can proceed |
| ren_src0 | input | 4 | First source architectural register |
| ren_src1 | input | 4 | Second source architectural register |
| ren_dst_en | input | 1 | The instruction writes a destination |
| ren_dst | input | 4 | Destination architectural register |
| ren_psrc0 | output | 6 | Physical tag for the first source |
| ren_psrc1 | output | 6 | Physical tag for the second source |
| ren_pdst | output | 6 | Newly allocated destination tag |
| ren_pold | output | 6 | Tag the destination held before renaming |
| cmt_valid | input | 1 | Commit of the oldest instruction |
| cmt_dst_en | input | 1 | The committing instruction has a destination |
| cmt_dst | input | 4 | Its destination architectural register |
| cmt_pdst | input | 6 | Its allocated physical tag |
| cmt_pold | input | 6 | Its previous tag, to be freed |
| flush | input | 1 | Restore the speculative state from the committed state |

## Verification
The assertions take for granted that the commit port is well formed. Commits arrive in rename order, each carries the `ren_pdst` and `ren_pold` that its instruction received, and no commit repeats an instruction that a flush has squashed. The bench keeps to this by holding an in-order queue of the renames that actually fired and committing only from its head. It empties the queue whenever it flushes. Under these conditions the pool bound and the release property hold.

// File: rtl/reg_rename.sv
module reg_rename #(
  parameter int NUM_ARCH = 16,
  parameter int NUM_PHYS = 64,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid,
  output logic          ren_ready,
  input  logic [AW-1:0] ren_src0,
  input  logic [AW-1:0] ren_src1,
  input  logic          ren_dst_en,
  input  logic [AW-1:0] ren_dst,
  output logic [PW-1:0] ren_psrc0,
  output logic [PW-1:0] ren_psrc1,
  output logic [PW-1:0] ren_pdst,
  output logic [PW-1:0] ren_pold,
  input  logic          cmt_valid,
  input  logic          cmt_dst_en,
  input  logic [AW-1:0] cmt_dst,
  input  logic [PW-1:0] cmt_pdst,
  input  logic [PW-1:0] cmt_pold,
  input  logic          flush
);

  logic [PW-1:0]       spec_q [NUM_ARCH];
  logic [PW-1:0]       ret_q  [NUM_ARCH];
  logic [PW-1:0]       ret_nx [NUM_ARCH];
  logic [NUM_PHYS-1:0] free_q, free_nx, ret_live;
  logic [PW-1:0]       pick;
  logic                pick_ok;

  always_comb begin
    pick    = '0;
    pick_ok = 1'b0;
    for (int i = NUM_PHYS - 1; i >= 0; i--)
      if (free_q[i]) begin
        pick    = PW'(i);
        pick_ok = 1'b1;
      end
  end

  wire take = ren_valid & pick_ok & ~flush & ren_dst_en;
  wire cmt  = cmt_valid & cmt_dst_en;

  assign ren_ready = pick_ok;
  assign ren_psrc0 = spec_q[ren_src0];
  assign ren_psrc1 = spec_q[ren_src1];
  assign ren_pold  = spec_q[ren_dst];
  assign ren_pdst  = pick;

  always_comb begin
    ret_nx = ret_q;
    if (cmt) ret_nx[cmt_dst] = cmt_pdst;
    ret_live = '0;
    for (int a = 0; a < NUM_ARCH; a++) ret_live[ret_nx[a]] = 1'b1;
  end

  always_comb begin
    if (flush)
      free_nx = ~ret_live;
    else
      free_nx = (free_q & ~({NUM_PHYS{take}} & (NUM_PHYS'(1) << pick)))
              | ({NUM_PHYS{cmt}} & (NUM_PHYS'(1) << cmt_pold));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < NUM_ARCH; a++) begin
        spec_q[a] <= PW'(a);
        ret_q[a]  <= PW'(a);
      end
      free_q <= {{(NUM_PHYS-NUM_ARCH){1'b1}}, {NUM_ARCH{1'b0}}};
    end else begin
      ret_q  <= ret_nx;
      free_q <= free_nx;
      if (flush)     spec_q <= ret_nx;
      else if (take) spec_q[ren_dst] <= pick;
    end
  end

endmodule

module reg_rename_checks #(
  parameter int NUM_ARCH = 16,
  parameter int NUM_PHYS = 64,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ren_valid,
  input logic                ren_ready,
  input logic                ren_dst_en,
  input logic [AW-1:0]       ren_dst,
  input logic [PW-1:0]       ren_pdst,
  input logic                cmt_valid,
  input logic                cmt_dst_en,
  input logic [PW-1:0]       cmt_pold,
  input logic                flush,
  input logic [PW-1:0]       spec_q [NUM_ARCH],
  input logic [PW-1:0]       ret_q  [NUM_ARCH],
  input logic [NUM_PHYS-1:0] free_q
);
  logic maps_eq;
  always_comb begin
    maps_eq = 1'b1;
    for (int a = 0; a < NUM_ARCH; a++)
      if (spec_q[a] != ret_q[a]) maps_eq = 1'b0;
  end

  wire alloc = ren_valid && ren_ready && !flush && ren_dst_en;

  p_alloc_from_pool_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> free_q[ren_pdst]);

  p_map_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> spec_q[$past(ren_dst)] == $past(ren_pdst));

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && cmt_dst_en && !flush) |=> free_q[$past(cmt_pold)]);

  p_flush_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> maps_eq);

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(free_q) <= NUM_PHYS - NUM_ARCH);
endmodule

bind reg_rename reg_rename_checks #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_ready(ren_ready),
  .ren_dst_en(ren_dst_en), .ren_dst(ren_dst), .ren_pdst(ren_pdst),
  .cmt_valid(cmt_valid), .cmt_dst_en(cmt_dst_en), .cmt_pold(cmt_pold),
  .flush(flush), .spec_q(spec_q), .ret_q(ret_q), .free_q(free_q)
);

// File: tb/reg_rename_bench.sv
module reg_rename_bench;
  localparam int NA = 16;
  localparam int NP = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ren_valid = 1'b0, ren_dst_en = 1'b0, cmt_valid = 1'b0, cmt_dst_en = 1'b0, flush = 1'b0;
  logic [3:0] ren_src0 = '0, ren_src1 = '0, ren_dst = '0, cmt_dst = '0;
  logic [5:0] cmt_pdst = '0, cmt_pold = '0;
  logic ren_ready;
  logic [5:0] ren_psrc0, ren_psrc1, ren_pdst, ren_pold;

  always #5 clk = ~clk;

  reg_rename u_reg_rename (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_ready(ren_ready),
    .ren_src0(ren_src0), .ren_src1(ren_src1), .ren_dst_en(ren_dst_en), .ren_dst(ren_dst),
    .ren_psrc0(ren_psrc0), .ren_psrc1(ren_psrc1), .ren_pdst(ren_pdst), .ren_pold(ren_pold),
    .cmt_valid(cmt_valid), .cmt_dst_en(cmt_dst_en), .cmt_dst(cmt_dst),
    .cmt_pdst(cmt_pdst), .cmt_pold(cmt_pold), .flush(flush)
  );

  int checks = 0, failures = 0;
  int spec_m [NA];
  int ret_m  [NA];
  bit free_m [NP];
  int qd [64];
  int qp [64];
  int qo [64];
  int qh = 0, qcnt = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int low_free();
    for (int p = 0; p < NP; p++) if (free_m[p]) return p;
    return -1;
  endfunction

  task automatic cyc(input bit rv, input int s0, input int s1, input bit de,
                     input int d, input bit cv, input bit fl);
    int lf, old, cd, cp, co;
    bit rdy, cmt;
    cmt = cv && (qcnt > 0);
    cd = qd[qh]; cp = qp[qh]; co = qo[qh];
    ren_valid = rv; ren_src0 = 4'(s0); ren_src1 = 4'(s1);
    ren_dst_en = de; ren_dst = 4'(d);
    cmt_valid = cmt; cmt_dst_en = 1'b1; cmt_dst = 4'(cd);
    cmt_pdst = 6'(cp); cmt_pold = 6'(co); flush = fl;
    #1;
    lf = low_free();
    rdy = (lf >= 0);
    old = spec_m[d];
    chk(ren_ready == rdy, "R6 ready", int'(ren_ready), int'(rdy));
    if (rv) begin
      chk(int'(ren_psrc0) == spec_m[s0], (de && s0 == d) ? "R5 src0" : "R2 src0",
          int'(ren_psrc0), spec_m[s0]);
      chk(int'(ren_psrc1) == spec_m[s1], (de && s1 == d) ? "R5 src1" : "R2 src1",
          int'(ren_psrc1), spec_m[s1]);
      if (de) chk(int'(ren_pold) == old, "R4 pold", int'(ren_pold), old);
      if (de && rdy) begin
        chk(int'(ren_pdst) == lf, "R3 pdst", int'(ren_pdst), lf);
        chk(free_m[ren_pdst], "R11 live tag reused", int'(ren_pdst), lf);
      end
    end
    @(posedge clk);
    if (cmt) ret_m[cd] = cp;
    if (rv && rdy && !fl && de) begin
      spec_m[d] = lf;
      free_m[lf] = 1'b0;
      qd[(qh + qcnt) % 64] = d; qp[(qh + qcnt) % 64] = lf; qo[(qh + qcnt) % 64] = old;
      qcnt++;
    end
    if (cmt) begin
      free_m[co] = 1'b1;
      qh = (qh + 1) % 64; qcnt--;
    end
    if (fl) begin
      for (int p = 0; p < NP; p++) free_m[p] = 1'b1;
      for (int a = 0; a < NA; a++) begin
        spec_m[a] = ret_m[a];
        free_m[ret_m[a]] = 1'b0;
      end
      qcnt = 0;
    end
    @(negedge clk);
  endtask

  task automatic sweep_sources();
    for (int a = 0; a < NA; a++) cyc(1, a, NA - 1 - a, 0, 0, 0, 0);
  endtask

  initial begin
    #1_000_000;
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int held;
    for (int a = 0; a < NA; a++) begin spec_m[a] = a; ret_m[a] = a; end
    for (int p = 0; p < NP; p++) free_m[p] = (p >= NA);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(ren_ready == 1'b1, "R1 ready after reset", int'(ren_ready), 1);
    for (int a = 0; a < NA; a++) begin
      ren_valid = 1; ren_src0 = 4'(a); ren_dst_en = 0; #1;
      chk(int'(ren_psrc0) == a, "R1 identity map", int'(ren_psrc0), a);
    end
    @(negedge clk);
    for (int i = 0; i < NA; i++)
      for (int j = 0; j < NA; j++) cyc(1, i, j, 0, 0, 0, 0);
    // R10: no destination, nothing allocated
    cyc(1, 3, 4, 0, 5, 0, 0);
    chk(low_free() == NA, "R10 pool untouched", low_free(), NA);
    // R5: sources equal destination
    cyc(1, 3, 3, 1, 3, 0, 0);
    cyc(1, 3, 3, 1, 3, 0, 0);
    // drain the pool
    for (int k = 0; k < 60 && low_free() >= 0; k++) cyc(1, k % NA, (k + 1) % NA, 1, k % NA, 0, 0);
    chk(ren_ready == 1'b0, "R6 empty pool stalls", int'(ren_ready), 0);
    cyc(1, 2, 7, 1, 2, 0, 0);
    sweep_sources();
    // R7: commit and rename in the same cycle
    held = qo[qh];
    cyc(1, 1, 1, 1, 9, 1, 0);
    #1;
    chk(ren_ready == 1'b1, "R7 freed tag next cycle", int'(ren_ready), 1);
    chk(int'(ren_pdst) == held, "R7 freed tag allocated", int'(ren_pdst), held);
    cyc(1, 1, 1, 1, 9, 0, 0);
    for (int k = 0; k < 5; k++) cyc(0, 0, 0, 0, 0, 1, 0);
    // R8/R9: flush with a same-cycle commit and a discarded rename
    cyc(1, 4, 5, 1, 6, 1, 1);
    sweep_sources();
    for (int k = 0; k < 60 && low_free() >= 0; k++) cyc(1, k % NA, 0, 1, (k * 7) % NA, 0, 0);
    chk(ren_ready == 1'b0, "R9 rebuilt pool drained", int'(ren_ready), 0);
    for (int k = 0; k < 48; k++) cyc(0, 0, 0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0, 0, 1);
    sweep_sources();
    // random phase
    for (int n = 0; n < 4000; n++)
      cyc(($urandom % 4) != 0, $urandom % NA, $urandom % NA, ($urandom % 4) != 0,
          $urandom % NA, ($urandom % 2) == 0, ($urandom % 40) == 0);
    cyc(0, 0, 0, 0, 0, 0, 1);
    sweep_sources();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule